// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (one clock line, one data line, both open-drain). Behind the bus it holds a 2048-byte memory and one 8-bit configuration byte. The block samples both lines with the system clock, finds START and STOP conditions, and shifts in an address byte. Its upper four bits carry a device-type code. One fixed code reaches the configuration byte. The code that reaches the memory is chosen by a bit of that configuration byte.

The block never drives the clock line and never begins a transfer. It pulls data low only to acknowledge a byte or to send a zero while reading. The memory supports byte writes, which continue to consecutive addresses, and sequential reads. The configuration byte can be read back. A lock bit in that byte refuses any later write to it. The eleven-bit memory address comes from the three bits that follow the device-type code, plus one word-address byte.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0) and the configuration byte `cfg_o` reads 0x00.
- R2: After a STOP, and after any NACK, the block leaves the data line released and ignores clocked bytes until the next START.
- R3: The memory answers device-type code 1010 (address-byte bits 7:4) when configuration bit 0 is 0, and code 1011 when it is 1. Any other code, except the configuration code, is NACKed.
- R4: Code 1001 reaches the configuration byte. Address-byte bits 3:1 must equal `pin_bias_i`, unless configuration bit 1 is set, in which case they are ignored. A write stores the data byte and a read returns the stored byte.
- R5: For an accepted byte the block holds the data line low for the whole high phase of the ninth clock. For a rejected byte it leaves the line released.
- R6: A memory write with address byte {code, A[10:8], 0}, word-address byte A[7:0] and one data byte stores the data at A. A later read of A returns it.
- R7: During a read, each master ACK advances the address by one, wrapping from 2047 to 0. The read address takes bits 10:8 from the read address byte and bits 7:0 from the current pointer.
- R8: When the master NACKs a read byte, the block stops sending and leaves the data line released on the clocks that follow.
- R9: When configuration bit 7 (lock) is set, a data byte written to the configuration byte is NACKed and the byte keeps its value.
- R10: The block changes its data-line drive only while the clock line is low.
- R11: Further data bytes in one write transaction go to consecutive addresses, wrapping from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| pin_bias_i | input | 3 | Strapped address bits compared on configuration accesses |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| cfg_o | output | 8 | Current configuration byte: bit0 memory-code select, bit1 ignore bias bits, bit7 lock |

## Verification
All sixteen device-type codes are swept once with each memory-code selection. This separates the configuration code, the selected memory code and its sibling. Bias-bit mismatches with the ignore bit cleared and set show whether the compare really is switched off. Memory accesses at eight addresses spread over all eight high-bit values check how the address byte and word byte join. Transactions that straddle address 2047 in both directions expose a wrong wrap or a missing carry into the high bits. Bytes clocked after a STOP, after a master NACK, and to a locked configuration byte each show whether the block really stays silent or refuses the write.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int          ADDR_W      = 11,
  parameter logic [3:0]  CFG_CODE    = 4'b1001,
  parameter logic [2:0]  MEM_CODE_HI = 3'b101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] pin_bias_i,
  output logic       sda_oe_o,
  output logic [7:0] cfg_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_DEV  = 3'd1;
  localparam logic [2:0] S_WADR = 3'd2;
  localparam logic [2:0] S_WDAT = 3'd3;
  localparam logic [2:0] S_RD   = 3'd4;

  logic [2:0]        scl_p, sda_p;
  logic [2:0]        state;
  logic [3:0]        bitcnt;
  logic              ackph;
  logic              to_cfg;
  logic [7:0]        sreg, tx, cfg_q;
  logic [ADDR_W-1:0] addr;
  logic              oe;
  logic [7:0]        mem [DEPTH];

  wire rise  =  scl_p[1] & ~scl_p[2];
  wire fall  = ~scl_p[1] &  scl_p[2];
  wire start =  scl_p[1] &  scl_p[2] &  sda_p[2] & ~sda_p[1];
  wire stop  =  scl_p[1] &  scl_p[2] & ~sda_p[2] &  sda_p[1];

  wire       bias_ok = cfg_q[1] | (sreg[3:1] == pin_bias_i);
  wire       hit_cfg = (sreg[7:4] == CFG_CODE) & bias_ok;
  wire       hit_mem = (sreg[7:4] == {MEM_CODE_HI, cfg_q[0]});
  wire       byte_end = fall & ~ackph & (bitcnt == 4'd8);
  wire [7:0] rd_byte = to_cfg ? cfg_q : mem[addr];
  wire       mem_we  = byte_end & (state == S_WDAT) & ~to_cfg;

  logic byte_ok;
  always_comb begin
    case (state)
      S_DEV:   byte_ok = hit_cfg | hit_mem;
      S_WADR:  byte_ok = 1'b1;
      S_WDAT:  byte_ok = ~to_cfg | ~cfg_q[7];
      default: byte_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= sreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p  <= 3'b111;
      sda_p  <= 3'b111;
      state  <= S_IDLE;
      bitcnt <= 4'd0;
      ackph  <= 1'b0;
      to_cfg <= 1'b0;
      sreg   <= 8'h00;
      tx     <= 8'h00;
      cfg_q  <= 8'h00;
      addr   <= '0;
      oe     <= 1'b0;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
      if (start) begin
        state  <= S_DEV;
        bitcnt <= 4'd0;
        ackph  <= 1'b0;
        oe     <= 1'b0;
      end else if (stop) begin
        state <= S_IDLE;
        ackph <= 1'b0;
        oe    <= 1'b0;
      end else if (state != S_IDLE) begin
        if (rise) begin
          if (bitcnt != 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            if (state != S_RD) sreg <= {sreg[6:0], sda_p[1]};
          end else if (state == S_RD && !ackph) begin
            if (sda_p[1]) begin
              state <= S_IDLE;
            end else begin
              ackph <= 1'b1;
              if (!to_cfg) addr <= addr + 1'b1;
            end
          end
        end else if (fall) begin
          if (ackph) begin
            ackph  <= 1'b0;
            bitcnt <= 4'd0;
            if (state == S_RD) begin
              tx <= rd_byte;
              oe <= ~rd_byte[7];
            end else begin
              oe <= 1'b0;
            end
          end else if (bitcnt == 4'd8) begin
            if (state == S_RD) begin
              oe <= 1'b0;
            end else if (!byte_ok) begin
              state <= S_IDLE;
              oe    <= 1'b0;
            end else begin
              oe    <= 1'b1;
              ackph <= 1'b1;
              case (state)
                S_DEV: begin
                  to_cfg <= hit_cfg;
                  if (hit_mem) addr[ADDR_W-1:8] <= sreg[HI_W:1];
                  state <= sreg[0] ? S_RD : (hit_cfg ? S_WDAT : S_WADR);
                end
                S_WADR: begin
                  addr[7:0] <= sreg;
                  state     <= S_WDAT;
                end
                default: begin
                  if (to_cfg) cfg_q <= sreg;
                  else        addr  <= addr + 1'b1;
                end
              endcase
            end
          end else if (state == S_RD) begin
            oe <= ~tx[6];
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_oe_o = oe;
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/twm_checker.sv
module twm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       ackph,
  input logic [2:0] state,
  input logic [7:0] cfg
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe); // R2

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[7] |=> (cfg[7] && $stable(cfg))); // R9

  AST_RX_DRIVE_ACK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 3'd1 || state == 3'd2 || state == 3'd3) && sda_oe) |-> ackph); // R5
endmodule

bind twowire_mem_slave twm_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .scl_s (scl_p[1]),
  .sda_oe(sda_oe_o),
  .ackph (ackph),
  .state (state),
  .cfg   (cfg_q)
);

// File: tb/twowire_mem_slave_tb.sv
module twowire_mem_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic sda_oe;
  logic [7:0] cfg;
  wire sda_bus = sda_m & ~sda_oe;

  int vec = 0;
  int mis = 0;
  int viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [2048];

  always #2 clk = ~clk;

  twowire_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .pin_bias_i(pins), .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) viol++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      mis++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(10);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0; tick(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(10);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    bit held;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(10);
      scl_m = 1'b1; tick(20);
      scl_m = 1'b0; tick(10);
    end
    sda_m = 1'b1; tick(10);
    scl_m = 1'b1; tick(1);
    held = ~sda_bus;
    tick(9);
    ack = ~sda_bus;
    tick(9);
    ack = ack & held & ~sda_bus;
    tick(1);
    scl_m = 1'b0; tick(10);
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(10);
      scl_m = 1'b1; tick(10);
      b = {b[6:0], sda_bus};
      tick(10);
      scl_m = 1'b0; tick(10);
    end
    sda_m = mack ? 1'b0 : 1'b1; tick(10);
    scl_m = 1'b1; tick(20);
    scl_m = 1'b0; tick(10);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 7 + 8'h5A) ^ (a >> 8));
  endfunction

  task automatic cfg_write(input logic [2:0] bias, input logic [7:0] d, output bit a0, output bit a1);
    bus_start();
    send({4'b1001, bias, 1'b0}, a0);
    send(d, a1);
    bus_stop();
  endtask

  initial begin
    bit a0, a1, a2;
    logic [7:0] rb;
    tick(10);
    rst_n = 1'b1;
    tick(10);
    check(sda_oe == 1'b0, "R1 released", sda_oe, 0);
    check(cfg == 8'h00, "R1 cfg", cfg, 0);

    for (int code = 0; code < 16; code++) begin
      bus_start();
      send({4'(code), 3'b101, 1'b0}, a0);
      bus_stop();
      check(a0 == (code == 9 || code == 10), "R3 R4 code sweep sel0", a0, (code == 9 || code == 10));
    end

    bus_start(); send({4'b1001, 3'b010, 1'b0}, a0); bus_stop();
    check(a0 == 1'b0, "R4 bias mismatch nack", a0, 0);

    cfg_write(3'b101, 8'h03, a0, a1);
    check(a0 && a1 && cfg == 8'h03, "R4 cfg write", {a0, a1, cfg}, {2'b11, 8'h03});

    bus_start(); send({4'b1001, 3'b010, 1'b0}, a0); bus_stop();
    check(a0 == 1'b1, "R4 bias ignored ack", a0, 1);

    for (int code = 0; code < 16; code++) begin
      bus_start();
      send({4'(code), 3'b000, 1'b0}, a0);
      bus_stop();
      check(a0 == (code == 9 || code == 11), "R3 R4 code sweep sel1", a0, (code == 9 || code == 11));
    end

    cfg_write(3'b000, 8'h00, a0, a1);
    check(a0 && a1 && cfg == 8'h00, "R4 cfg clear", {a0, a1, cfg}, {2'b11, 8'h00});

    for (int k = 0; k < 8; k++) begin
      int a;
      a = k * 256 + ((k * 37 + 3) % 256);
      bus_start();
      send({4'b1010, 3'(k), 1'b0}, a0);
      send(8'(a), a1);
      send(pattern(a), a2);
      bus_stop();
      model[a] = pattern(a);
      check(a0 && a1 && a2, "R5 R6 write acks", {a0, a1, a2}, 3'b111);
    end

    bus_start();
    send({4'b1010, 3'b111, 1'b0}, a0);
    send(8'hFE, a1);
    check(a0 && a1, "R5 R11 addr acks", {a0, a1}, 2'b11);
    for (int j = 0; j < 4; j++) begin
      int a;
      a = (2046 + j) % 2048;
      send(pattern(a + 1000), a2);
      model[a] = pattern(a + 1000);
      check(a2, "R11 burst ack", a2, 1);
    end
    bus_stop();

    for (int k = 0; k < 8; k++) begin
      int a;
      a = k * 256 + ((k * 37 + 3) % 256);
      bus_start();
      send({4'b1010, 3'(k), 1'b0}, a0);
      send(8'(a), a1);
      bus_start();
      send({4'b1010, 3'(k), 1'b1}, a2);
      recv(1'b0, rb);
      bus_stop();
      check(a0 && a1 && a2 && rb == model[a], "R6 readback", {a0, a1, a2, rb}, {3'b111, model[a]});
    end

    bus_start();
    send({4'b1010, 3'b111, 1'b0}, a0);
    send(8'hFE, a1);
    bus_start();
    send({4'b1010, 3'b111, 1'b1}, a2);
    check(a0 && a1 && a2, "R7 setup acks", {a0, a1, a2}, 3'b111);
    for (int j = 0; j < 4; j++) begin
      int a;
      a = (2046 + j) % 2048;
      recv(j != 3, rb);
      check(rb == model[a], "R7 R11 sequential wrap", rb, model[a]);
    end
    recv(1'b0, rb);
    check(rb == 8'hFF, "R8 silent after master nack", rb, 8'hFF);
    bus_stop();

    send({4'b1010, 3'b000, 1'b0}, a0);
    check(a0 == 1'b0, "R2 ignored after stop", a0, 0);
    bus_stop();

    bus_start();
    send({4'b1001, 3'b101, 1'b1}, a0);
    recv(1'b0, rb);
    bus_stop();
    check(a0 && rb == 8'h00, "R4 cfg read", {a0, rb}, {1'b1, 8'h00});

    cfg_write(3'b101, 8'h80, a0, a1);
    check(a0 && a1 && cfg == 8'h80, "R9 set lock", {a0, a1, cfg}, {2'b11, 8'h80});
    cfg_write(3'b101, 8'h03, a0, a1);
    check(a0 == 1'b1 && a1 == 1'b0, "R9 locked data nack", {a0, a1}, 2'b10);
    check(cfg == 8'h80, "R9 locked value kept", cfg, 8'h80);
    bus_start();
    send({4'b1001, 3'b101, 1'b1}, a0);
    recv(1'b0, rb);
    bus_stop();
    check(a0 && rb == 8'h80, "R9 R4 locked readback", {a0, rb}, {1'b1, 8'h80});

    bus_start();
    send({4'b1010, 3'b000, 1'b0}, a0);
    send(8'h03, a1);
    bus_start();
    send({4'b1010, 3'b000, 1'b1}, a2);
    recv(1'b0, rb);
    bus_stop();
    check(a0 && a1 && a2 && rb == model[3], "R6 R3 memory after lock", {a0, a1, a2, rb}, {3'b111, model[3]});

    check(viol == 0, "R10 drive changes while clock high", viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule